// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR-style flash device. It samples every write the host makes and turns the multi-write unlock sequences into requests for the program and erase machinery. Those requests are: program one byte, erase the whole chip, erase one or more sectors, and suspend or resume an erase in progress. Each request is a single-cycle pulse that carries the address and data it needs. The block also holds the read path in one of two modes. In array mode, reads pass straight through from the cell array. In identifier mode, reads return fixed manufacturer and device codes.

Every long command starts with two unlock writes. The third write picks the command. An erase command needs two more unlock writes before its sixth and final write. After a sector erase, a short accumulation window stays open, and during it further sector addresses may be queued. When the window closes, the controller's busy input decides what is accepted. A write the decoder does not expect aborts the sequence in progress.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in array mode with no request pending, the accumulation window is closed, and `rd_data` equals `array_rdata`.
- R2: The unlock steps are a write of AAh at key address A (5555h) followed by a write of 55h at key address B (2AAAh). Only the low `CMP_W` (15) address bits are compared, so the upper address bits have no effect on matching.
- R3: The third write at key address A selects the command. 90h enters identifier mode. In identifier mode, `rd_addr` 0 reads 10h and `rd_addr` 1 reads 3Eh when `TOP_VARIANT`=1 or 37h when it is 0; every other address reads 00h. Outside identifier mode `rd_data` equals `array_rdata`.
- R4: A third write of A0h arms a program. The next write, at any address, raises `prog_req` for one cycle, the cycle after the write is sampled, with that write's address and data. At most one request pulse is high in any cycle.
- R5: A third write of 80h arms erase. The writes that must follow are AAh at A, 55h at B, then 10h at key address A. That sequence raises `chip_erase_req`. A 10h at any other address aborts the sequence with no request.
- R6: If that sixth write is 30h at any address, `sect_erase_req` pulses with `sect_addr` set to the write address, and `accum_open` goes high.
- R7: After a sector request the window stays open for `WIN_CYCLES` cycles. While it is open, each 30h write queues one more sector request and restarts the window, and every other write is ignored. Once it has closed, a 30h write produces no sector request.
- R8: A write of F0h at any address, while not busy, returns the decoder to array mode and abandons any partial sequence.
- R9: Any write, while not busy, that does not match the expected address and data for the current step aborts the sequence and leaves identifier mode.
- R10: While `busy` is high and the window is closed, every write except B0h is ignored, and a partial sequence is kept. A B0h write that arrives while not already suspended raises `suspend_pulse`.
- R11: While suspended, a 30h write raises `resume_pulse` once and clears the suspended state. A further 30h write raises no resume pulse.
- R12: A 30h write sampled in the last open cycle of the window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation in progress |
| rd_addr | input | AW | Read address |
| array_rdata | input | 8 | Data read from the cell array |
| rd_data | output | 8 | Read data after the mode mux |
| id_mode | output | 1 | Identifier mode active |
| prog_req | output | 1 | Program request pulse |
| prog_addr | output | AW | Program target address |
| prog_data | output | 8 | Program byte |
| chip_erase_req | output | 1 | Chip erase request pulse |
| sect_erase_req | output | 1 | Sector erase request pulse |
| sect_addr | output | AW | Address of the sector to erase |
| suspend_pulse | output | 1 | Erase suspend pulse |
| resume_pulse | output | 1 | Erase resume pulse |
| accum_open | output | 1 | Sector accumulation window is open |

## Verification
The window timeout and an incoming 30h write can fall in the same cycle. In that cycle the window counter is expiring while a new sector is asking to be queued. The bench provokes this by waiting exactly `WIN_CYCLES`-1 idle cycles after a sector request before writing 30h. It then judges the outcome by requiring a fresh `sect_erase_req` with the new address and a reopened window. A second run waits one cycle longer, and there the same write must produce no request at all.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS3, ST_ERS4, ST_ERS5
    } seq_e;

    localparam logic [7:0] KEY_A_DATA = 8'hAA;
    localparam logic [7:0] KEY_B_DATA = 8'h55;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_PROG    = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_SECT    = 8'h30;
    localparam logic [7:0] OP_SUSP    = 8'hB0;
    localparam logic [7:0] CODE_MFR   = 8'h10;
    localparam logic [7:0] CODE_TOP   = 8'h3E;
    localparam logic [7:0] CODE_BOT   = 8'h37;
endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
    parameter int CMP_W = 15
) (
    input  logic [CMP_W-1:0] addr,
    output logic             hit_a,
    output logic             hit_b
);
    localparam logic [CMP_W-1:0] ADDR_A = CMP_W'(15'h5555);
    localparam logic [CMP_W-1:0] ADDR_B = CMP_W'(15'h2AAA);

    assign hit_a = (addr == ADDR_A);
    assign hit_b = (addr == ADDR_B);
endmodule

// File: rtl/fcd_erase_window.sv
module fcd_erase_window #(
    parameter int WIN_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic open_o
);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] cnt;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (start) begin
            win_d.open = 1'b1;
            win_d.cnt  = CW'(WIN_CYCLES - 1);
        end else if (win_q.open) begin
            if (win_q.cnt == '0) begin
                win_d.open = 1'b0;
            end else begin
                win_d.cnt = win_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign open_o = win_q.open;
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux import fcd_pkg::*; #(
    parameter int AW          = 20,
    parameter bit TOP_VARIANT = 1'b1
) (
    input  logic          id_mode,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    array_rdata,
    output logic [7:0]    rd_data
);
    logic [7:0] dev_code;

    generate
        if (TOP_VARIANT) begin : g_top
            assign dev_code = CODE_TOP;
        end else begin : g_bot
            assign dev_code = CODE_BOT;
        end
    endgenerate

    always_comb begin
        if (!id_mode)                 rd_data = array_rdata;
        else if (rd_addr == AW'(0))   rd_data = CODE_MFR;
        else if (rd_addr == AW'(1))   rd_data = dev_code;
        else                          rd_data = 8'h00;
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder import fcd_pkg::*; #(
    parameter int AW          = 20,
    parameter int CMP_W       = 15,
    parameter int WIN_CYCLES  = 8,
    parameter bit TOP_VARIANT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          busy,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    array_rdata,
    output logic [7:0]    rd_data,
    output logic          id_mode,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [7:0]    prog_data,
    output logic          chip_erase_req,
    output logic          sect_erase_req,
    output logic [AW-1:0] sect_addr,
    output logic          suspend_pulse,
    output logic          resume_pulse,
    output logic          accum_open
);
    typedef struct packed {
        seq_e          state;
        logic          id;
        logic          suspended;
        logic          prog_req;
        logic [AW-1:0] prog_addr;
        logic [7:0]    prog_data;
        logic          chip_req;
        logic          sect_req;
        logic [AW-1:0] sect_addr;
        logic          susp_p;
        logic          res_p;
    } dec_t;

    dec_t dec_d, dec_q;
    logic hit_a, hit_b, win_open, win_start, match;

    fcd_addr_match #(.CMP_W(CMP_W)) u_match (
        .addr  (wr_addr[CMP_W-1:0]),
        .hit_a (hit_a),
        .hit_b (hit_b)
    );

    fcd_erase_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (win_start),
        .open_o (win_open)
    );

    fcd_id_mux #(.AW(AW), .TOP_VARIANT(TOP_VARIANT)) u_mux (
        .id_mode     (dec_q.id),
        .rd_addr     (rd_addr),
        .array_rdata (array_rdata),
        .rd_data     (rd_data)
    );

    always_comb begin
        dec_d          = dec_q;
        dec_d.prog_req = 1'b0;
        dec_d.chip_req = 1'b0;
        dec_d.sect_req = 1'b0;
        dec_d.susp_p   = 1'b0;
        dec_d.res_p    = 1'b0;
        win_start      = 1'b0;
        match          = 1'b1;
        if (wr_en) begin
            if (win_open) begin
                if (wr_data == OP_SECT) begin
                    dec_d.sect_req  = 1'b1;
                    dec_d.sect_addr = wr_addr;
                    win_start       = 1'b1;
                end
            end else if (dec_q.suspended && wr_data == OP_SECT) begin
                dec_d.res_p     = 1'b1;
                dec_d.suspended = 1'b0;
                dec_d.state     = ST_IDLE;
            end else if (busy) begin
                if (wr_data == OP_SUSP && !dec_q.suspended) begin
                    dec_d.susp_p    = 1'b1;
                    dec_d.suspended = 1'b1;
                end
            end else begin
                unique case (dec_q.state)
                    ST_IDLE: begin
                        match = hit_a && wr_data == KEY_A_DATA;
                        dec_d.state = ST_UNL1;
                    end
                    ST_UNL1: begin
                        match = hit_b && wr_data == KEY_B_DATA;
                        dec_d.state = ST_UNL2;
                    end
                    ST_UNL2: begin
                        match = hit_a && (wr_data == OP_IDENT || wr_data == OP_PROG
                                          || wr_data == OP_ERASE);
                        if (wr_data == OP_IDENT) begin
                            dec_d.id    = 1'b1;
                            dec_d.state = ST_IDLE;
                        end else if (wr_data == OP_PROG) begin
                            dec_d.state = ST_PROG;
                        end else begin
                            dec_d.state = ST_ERS3;
                        end
                    end
                    ST_PROG: begin
                        dec_d.prog_req  = 1'b1;
                        dec_d.prog_addr = wr_addr;
                        dec_d.prog_data = wr_data;
                        dec_d.id        = 1'b0;
                        dec_d.state     = ST_IDLE;
                    end
                    ST_ERS3: begin
                        match = hit_a && wr_data == KEY_A_DATA;
                        dec_d.state = ST_ERS4;
                    end
                    ST_ERS4: begin
                        match = hit_b && wr_data == KEY_B_DATA;
                        dec_d.state = ST_ERS5;
                    end
                    ST_ERS5: begin
                        dec_d.state = ST_IDLE;
                        dec_d.id    = 1'b0;
                        if (hit_a && wr_data == OP_CHIP) begin
                            dec_d.chip_req = 1'b1;
                        end else if (wr_data == OP_SECT) begin
                            dec_d.sect_req  = 1'b1;
                            dec_d.sect_addr = wr_addr;
                            win_start       = 1'b1;
                        end else begin
                            match = 1'b0;
                        end
                    end
                    default: match = 1'b0;
                endcase
                if (!match) begin
                    dec_d.state = ST_IDLE;
                    dec_d.id    = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign id_mode        = dec_q.id;
    assign prog_req       = dec_q.prog_req;
    assign prog_addr      = dec_q.prog_addr;
    assign prog_data      = dec_q.prog_data;
    assign chip_erase_req = dec_q.chip_req;
    assign sect_erase_req = dec_q.sect_req;
    assign sect_addr      = dec_q.sect_addr;
    assign suspend_pulse  = dec_q.susp_p;
    assign resume_pulse   = dec_q.res_p;
    assign accum_open     = win_open;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic          busy,
    input logic [AW-1:0] rd_addr,
    input logic [7:0]    array_rdata,
    input logic [7:0]    rd_data,
    input logic          id_mode,
    input logic          prog_req,
    input logic          chip_erase_req,
    input logic          sect_erase_req,
    input logic          suspend_pulse,
    input logic          resume_pulse,
    input logic          accum_open
);
    assert_one_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, chip_erase_req, sect_erase_req, suspend_pulse, resume_pulse}));

    assert_prog_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wr_en));

    assert_suspend_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_pulse |-> ($past(busy) && $past(wr_en) && $past(wr_data) == 8'hB0));

    assert_resume_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ($past(wr_en) && $past(wr_data) == 8'h30));

    assert_sector_opens_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sect_erase_req |-> accum_open);

    assert_mfr_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && rd_addr == '0) |-> rd_data == 8'h10);

    assert_array_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> rd_data == array_rdata);
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .busy           (busy),
    .rd_addr        (rd_addr),
    .array_rdata    (array_rdata),
    .rd_data        (rd_data),
    .id_mode        (id_mode),
    .prog_req       (prog_req),
    .chip_erase_req (chip_erase_req),
    .sect_erase_req (sect_erase_req),
    .suspend_pulse  (suspend_pulse),
    .resume_pulse   (resume_pulse),
    .accum_open     (accum_open)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
    localparam int AW  = 20;
    localparam int WIN = 8;
    localparam logic [AW-1:0] KA = 20'h05555;
    localparam logic [AW-1:0] KB = 20'h02AAA;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, busy = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, array_rdata = 8'hC3;
    logic [7:0] rd_data, rd_data_b, prog_data, prog_data_b;
    logic [AW-1:0] prog_addr, sect_addr, prog_addr_b, sect_addr_b;
    logic id_mode, prog_req, chip_erase_req, sect_erase_req, suspend_pulse, resume_pulse, accum_open;
    logic id_b, pr_b, ce_b, se_b, sp_b, rp_b, ao_b;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.AW(AW), .WIN_CYCLES(WIN), .TOP_VARIANT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data),
        .id_mode(id_mode), .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req), .sect_addr(sect_addr),
        .suspend_pulse(suspend_pulse), .resume_pulse(resume_pulse), .accum_open(accum_open));

    flash_cmd_decoder #(.AW(AW), .WIN_CYCLES(WIN), .TOP_VARIANT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data_b),
        .id_mode(id_b), .prog_req(pr_b), .prog_addr(prog_addr_b), .prog_data(prog_data_b),
        .chip_erase_req(ce_b), .sect_erase_req(se_b), .sect_addr(sect_addr_b),
        .suspend_pulse(sp_b), .resume_pulse(rp_b), .accum_open(ao_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write is sampled at the next rising edge,
    // and outputs are observed at the falling edge after it
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        wr(KA, 8'hAA);
        wr(KB, 8'h55);
    endtask

    function automatic logic [31:0] pulses();
        return {27'd0, prog_req, chip_erase_req, sect_erase_req, suspend_pulse, resume_pulse};
    endfunction

    task automatic sector_cmd(input logic [AW-1:0] sa);
        unlock();
        wr(KA, 8'h80);
        unlock();
        wr(sa, 8'h30);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 id_mode", id_mode, 0);
        chk("R1 pulses", pulses(), 0);
        chk("R1 accum_open", accum_open, 0);
        chk("R1 rd_data", rd_data, 8'hC3);

        // R3: identifier mode read sweep
        unlock();
        wr(KA, 8'h90);
        chk("R3 id entry", id_mode, 1);
        for (int i = 0; i < 16; i++) begin
            rd_addr = AW'(i);
            #1;
            chk("R3 id read top", rd_data, (i == 0) ? 8'h10 : (i == 1) ? 8'h3E : 8'h00);
            chk("R3 id read bottom", rd_data_b, (i == 0) ? 8'h10 : (i == 1) ? 8'h37 : 8'h00);
        end
        rd_addr = '0;
        // R8: F0h at an arbitrary address
        wr(20'hABCDE, 8'hF0);
        chk("R8 reset cmd", id_mode, 0);
        chk("R3 array passthrough", rd_data, 8'hC3);

        // R2: upper address bits do not affect matching
        for (int hi = 0; hi < 32; hi++) begin
            wr({hi[4:0], 15'h5555}, 8'hAA);
            wr({hi[4:0], 15'h2AAA}, 8'h55);
            wr({hi[4:0], 15'h5555}, 8'h90);
            chk("R2 upper bits ignored", id_mode, 1);
            wr(KA, 8'hF0);
        end

        // R3 R4 R9: sweep of every third-cycle byte
        for (int d = 0; d < 256; d++) begin
            unlock();
            wr(KA, 8'(d));
            chk("R3 R9 command select", id_mode, (d == 8'h90) ? 1 : 0);
            if (d == 8'hA0) begin
                wr(20'h3A5C1, 8'h5A);
                chk("R4 prog pulse", prog_req, 1);
                chk("R4 prog addr", prog_addr, 20'h3A5C1);
                chk("R4 prog data", prog_data, 8'h5A);
                idle(1);
                chk("R4 prog single cycle", prog_req, 0);
            end
            wr(KA, 8'hF0);
        end

        // R9: wrong address in an unlock step aborts
        wr(KA, 8'hAA);
        wr(20'h01234, 8'h55);
        wr(KA, 8'h90);
        chk("R9 abort on address", id_mode, 0);
        unlock();
        wr(KA, 8'h90);
        wr(20'h00000, 8'h77);
        chk("R9 mismatch leaves id", id_mode, 0);

        // R5: chip erase, and 10h away from key address
        unlock(); wr(KA, 8'h80); unlock();
        wr(KA, 8'h10);
        chk("R5 chip erase", pulses(), 32'b01000);
        unlock(); wr(KA, 8'h80); unlock();
        wr(20'h01234, 8'h10);
        chk("R5 chip wrong address", pulses(), 0);

        // R6 R7 R12: sector erase and accumulation window
        sector_cmd(20'h40000);
        chk("R6 sector pulse", pulses(), 32'b00100);
        chk("R6 sector addr", sect_addr, 20'h40000);
        chk("R6 window open", accum_open, 1);
        idle(WIN - 1);
        chk("R7 window still open", accum_open, 1);
        wr(20'h50000, 8'h30);
        chk("R12 last cycle accepted", sect_erase_req, 1);
        chk("R12 sector addr", sect_addr, 20'h50000);
        wr(KB, 8'h55);
        chk("R7 other write ignored", pulses(), 0);
        wr(20'h60000, 8'h30);
        chk("R7 append after ignore", sect_erase_req, 1);
        chk("R7 append addr", sect_addr, 20'h60000);
        idle(WIN);
        chk("R7 window closed", accum_open, 0);
        sector_cmd(20'h70000);
        busy = 1'b1;
        idle(WIN);
        wr(20'h80000, 8'h30);
        chk("R7 late sector rejected", pulses(), 0);

        // R10 R11: busy filtering, suspend and resume
        busy = 1'b0;
        unlock();
        busy = 1'b1;
        wr(20'h00010, 8'h12);
        wr(KA, 8'h90);
        chk("R10 ignored while busy", id_mode, 0);
        busy = 1'b0;
        wr(KA, 8'h90);
        chk("R10 sequence kept", id_mode, 1);
        wr(KA, 8'hF0);
        busy = 1'b1;
        wr(20'h00000, 8'hB0);
        chk("R10 suspend pulse", pulses(), 32'b00010);
        wr(20'h00000, 8'hB0);
        chk("R10 no second suspend", pulses(), 0);
        busy = 1'b0;
        wr(20'h00000, 8'h30);
        chk("R11 resume pulse", pulses(), 32'b00001);
        wr(20'h00000, 8'h30);
        chk("R11 no second resume", pulses(), 0);

        // R1: reset in the middle of identifier mode
        unlock();
        wr(KA, 8'h90);
        rst_n = 1'b0;
        idle(1);
        chk("R1 reset clears id", id_mode, 0);
        rst_n = 1'b1;
        idle(1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule